// File: doc/BRIEF.md
# GF(2) Vector-Matrix Multiplier

This block multiplies a 1-by-M bit row vector A by a fixed M-by-N bit matrix H with modulo-2 arithmetic: every product is a bitwise AND and every sum is an XOR. The result is the N-bit row vector R. The matrix lives in an internal read-only store that is filled at elaboration time. It is laid out one column after another, so a single incrementing index walks every entry in the order the arithmetic needs it.

The block runs as a fixed-length loop through four phases: idle, load, accumulate and drain.
- **Load.** The vector bits enter serially on `a_bit_i`, one per clock with A[0] first, and go into an internal bit RAM.
- **Accumulate.** This phase takes M×N cycles. One AND/XOR accumulator folds in one product term per cycle. At each column boundary the finished column sum is written to a result RAM, and the accumulator is cleared on the same edge.
- **Drain.** The result bits are streamed out on `r_bit_o` with `r_valid_o`, R[0] first.

After the drain the block returns to idle and immediately starts loading the next vector. No handshake exists, so the source times its bits by cycle count from reset.

Top module: `gf2_vecmat_mul`

## Requirements
- R1: Each output bit equals R[j] = XOR over i of (A[i] AND H[j*M+i]). Here H[k] is bit k of parameter `H_COLMAJOR`, and column j occupies addresses j*M to j*M+M-1. With the default matrix (0xAD) and A = 1111, the output is R[0]=1 followed by R[1]=0.
- R2: On the first clock edge after reset is released, the block leaves idle. On the next M edges it samples `a_bit_i` as A[0], A[1], ... A[M-1], in that order.
- R3: The accumulate phase lasts exactly M×N cycles and is followed by the drain phase.
- R4: `r_valid_o` is high for exactly N consecutive cycles. It rises one cycle after the drain phase begins, and `r_bit_o` carries R[0] through R[N-1] in that order, one per cycle.
- R5: `r_valid_o` is low in every cycle that is not presenting a drained result bit.
- R6: After the last result bit, the block passes through idle and loads again. The next vector's A[0] is sampled 1+M+M×N+N edges after the previous vector's A[0].
- R7: A synchronous active-high `rst_i` clears all counters and the accumulator, forces the idle phase and drops `r_valid_o`. It does so even in the middle of a computation, and the next full operation after release gives a correct result.
- R8: The phases always follow the order idle, load, accumulate, drain, and then idle again.
- R9: The accumulator is cleared on the same edge that writes a column result. No term from one column or one vector reaches another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous active-high reset |
| a_bit_i | input | 1 | Serial vector bit, sampled during the load phase |
| r_bit_o | output | 1 | Serial result bit |
| r_valid_o | output | 1 | High while `r_bit_o` carries a result bit |

## Verification
The assertions check the following on every cycle:
- the phase order;
- the length of the load phase;
- the exact length of the accumulate phase, counted in the checker;
- the link between the drain phase and `r_valid_o`;
- that the accumulator clear coincides with each result write;
- the effect of reset.

Only the bench's scenarios can show that the streamed bits are the correct GF(2) products. It does this by sweeping all 2^M vectors back to back and comparing against an arithmetic reference. The same scenarios show that back-to-back vectors do not contaminate each other, and that an operation aborted by reset is followed by a correct one.

// File: rtl/gf2mm_pkg.sv
`timescale 1ns/1ps
package gf2mm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_MAC   = 2'd2,
        ST_DRAIN = 2'd3
    } gf2mm_state_e;

    // counter width for an index range of n entries, never below one bit
    function automatic int unsigned cw(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/gf2mm_ctrl.sv
`timescale 1ns/1ps
module gf2mm_ctrl
    import gf2mm_pkg::*;
#(
    parameter int unsigned M = 4,
    parameter int unsigned N = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    output gf2mm_state_e          state_o,
    output logic [cw(M)-1:0]      a_addr_o,
    output logic [cw(M*N)-1:0]    h_addr_o,
    output logic [cw(N)-1:0]      r_addr_o,
    output logic                  a_we_o,
    output logic                  h_en_o,
    output logic                  mac_en_o,
    output logic                  acc_clr_o,
    output logic                  r_we_o,
    output logic                  r_re_o
);
    localparam int unsigned AW = cw(M);
    localparam int unsigned HW = cw(M*N);
    localparam int unsigned RW = cw(N);

    typedef struct packed {
        gf2mm_state_e  st;
        logic [AW-1:0] ca;
        logic [HW-1:0] ch;
        logic [RW-1:0] cr;
    } ctrl_s;

    ctrl_s q, d;
    logic  a_last, h_last, r_last;

    always_comb begin
        d         = q;
        a_we_o    = 1'b0;
        h_en_o    = 1'b0;
        mac_en_o  = 1'b0;
        acc_clr_o = 1'b0;
        r_we_o    = 1'b0;
        r_re_o    = 1'b0;
        a_last    = (q.ca == AW'(M-1));
        h_last    = (q.ch == HW'(M*N-1));
        r_last    = (q.cr == RW'(N-1));
        unique case (q.st)
            ST_IDLE: begin
                d.ca      = '0;
                d.ch      = '0;
                d.cr      = '0;
                acc_clr_o = 1'b1;
                d.st      = ST_LOAD;
            end
            ST_LOAD: begin
                a_we_o = 1'b1;
                d.ca   = a_last ? '0 : q.ca + AW'(1);
                if (a_last) begin
                    // prefetch the first matrix entry so it is ready for the first product
                    h_en_o = 1'b1;
                    d.ch   = h_last ? '0 : q.ch + HW'(1);
                    d.st   = ST_MAC;
                end
            end
            ST_MAC: begin
                h_en_o   = 1'b1;
                mac_en_o = 1'b1;
                d.ch     = h_last ? '0 : q.ch + HW'(1);
                d.ca     = a_last ? '0 : q.ca + AW'(1);
                if (a_last) begin
                    // column finished: store sum including this term, restart accumulator
                    r_we_o    = 1'b1;
                    acc_clr_o = 1'b1;
                    d.cr      = r_last ? '0 : q.cr + RW'(1);
                    if (r_last) begin
                        d.st = ST_DRAIN;
                    end
                end
            end
            ST_DRAIN: begin
                r_re_o = 1'b1;
                d.cr   = r_last ? '0 : q.cr + RW'(1);
                if (r_last) begin
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q <= '{st: ST_IDLE, ca: '0, ch: '0, cr: '0};
        end else begin
            q <= d;
        end
    end

    assign state_o  = q.st;
    assign a_addr_o = q.ca;
    assign h_addr_o = q.ch;
    assign r_addr_o = q.cr;

endmodule

// File: rtl/gf2mm_bitmem.sv
`timescale 1ns/1ps
module gf2mm_bitmem #(
    parameter int unsigned DEPTH   = 4,
    parameter int unsigned AW      = 2,
    parameter bit          REG_OUT = 1'b0
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic          wdata_i,
    input  logic          re_i,
    input  logic [AW-1:0] raddr_i,
    output logic          rdata_o
);
    logic [DEPTH-1:0] mem_q, mem_d;

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            mem_d[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    generate
        if (REG_OUT) begin : g_reg_read
            logic rd_q, rd_d;
            always_comb begin
                rd_d = rd_q;
                if (re_i) begin
                    rd_d = mem_q[raddr_i];
                end
            end
            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    rd_q <= 1'b0;
                end else begin
                    rd_q <= rd_d;
                end
            end
            assign rdata_o = rd_q;
        end else begin : g_comb_read
            assign rdata_o = re_i & mem_q[raddr_i];
        end
    endgenerate

endmodule

// File: rtl/gf2mm_hrom.sv
`timescale 1ns/1ps
module gf2mm_hrom #(
    parameter int unsigned          DEPTH   = 8,
    parameter int unsigned          AW      = 3,
    parameter logic [DEPTH-1:0]     CONTENT = '0
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          en_i,
    input  logic [AW-1:0] addr_i,
    output logic          bit_o
);
    logic bit_q, bit_d;

    always_comb begin
        bit_d = bit_q;
        if (en_i) begin
            bit_d = CONTENT[addr_i];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            bit_q <= 1'b0;
        end else begin
            bit_q <= bit_d;
        end
    end

    assign bit_o = bit_q;

endmodule

// File: rtl/gf2mm_accum.sv
`timescale 1ns/1ps
module gf2mm_accum (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic clr_i,
    input  logic a_bit_i,
    input  logic h_bit_i,
    output logic sum_o,
    output logic acc_o
);
    logic acc_q, acc_d;

    // running sum including the current product term
    assign sum_o = acc_q ^ (a_bit_i & h_bit_i);

    always_comb begin
        acc_d = acc_q;
        if (clr_i) begin
            acc_d = 1'b0;
        end else if (en_i) begin
            acc_d = sum_o;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            acc_q <= 1'b0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/gf2_vecmat_mul.sv
`timescale 1ns/1ps
module gf2_vecmat_mul
    import gf2mm_pkg::*;
#(
    parameter int unsigned      M          = 4,
    parameter int unsigned      N          = 2,
    parameter logic [M*N-1:0]   H_COLMAJOR = 8'hAD
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic a_bit_i,
    output logic r_bit_o,
    output logic r_valid_o
);
    localparam int unsigned AW = cw(M);
    localparam int unsigned HW = cw(M*N);
    localparam int unsigned RW = cw(N);

    gf2mm_state_e  st;
    logic [AW-1:0] a_idx;
    logic [HW-1:0] h_idx;
    logic [RW-1:0] r_idx;
    logic          a_we, h_en, mac_en, acc_clr, r_we, r_re;
    logic          a_rd, h_rd, acc_sum, acc_q;
    logic          valid_q, valid_d;

    gf2mm_ctrl #(.M(M), .N(N)) u_ctrl (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .state_o   (st),
        .a_addr_o  (a_idx),
        .h_addr_o  (h_idx),
        .r_addr_o  (r_idx),
        .a_we_o    (a_we),
        .h_en_o    (h_en),
        .mac_en_o  (mac_en),
        .acc_clr_o (acc_clr),
        .r_we_o    (r_we),
        .r_re_o    (r_re)
    );

    gf2mm_bitmem #(.DEPTH(M), .AW(AW), .REG_OUT(1'b0)) u_vec_ram (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .we_i    (a_we),
        .waddr_i (a_idx),
        .wdata_i (a_bit_i),
        .re_i    (mac_en),
        .raddr_i (a_idx),
        .rdata_o (a_rd)
    );

    gf2mm_hrom #(.DEPTH(M*N), .AW(HW), .CONTENT(H_COLMAJOR)) u_mat_rom (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (h_en),
        .addr_i (h_idx),
        .bit_o  (h_rd)
    );

    gf2mm_accum u_accum (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .en_i    (mac_en),
        .clr_i   (acc_clr),
        .a_bit_i (a_rd),
        .h_bit_i (h_rd),
        .sum_o   (acc_sum),
        .acc_o   (acc_q)
    );

    gf2mm_bitmem #(.DEPTH(N), .AW(RW), .REG_OUT(1'b1)) u_res_ram (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .we_i    (r_we),
        .waddr_i (r_idx),
        .wdata_i (acc_sum),
        .re_i    (r_re),
        .raddr_i (r_idx),
        .rdata_o (r_bit_o)
    );

    // read data lags its address by one cycle, so the flag does too
    always_comb begin
        valid_d = (st == ST_DRAIN);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= valid_d;
        end
    end

    assign r_valid_o = valid_q;

endmodule

// File: rtl/gf2mm_chk.sv
`timescale 1ns/1ps
module gf2mm_chk
    import gf2mm_pkg::*;
#(
    parameter int unsigned M = 4,
    parameter int unsigned N = 2
) (
    input logic               clk,
    input logic               rst,
    input gf2mm_state_e       state,
    input logic [cw(M)-1:0]   a_idx,
    input logic               r_we,
    input logic               acc_clr,
    input logic               acc_q,
    input logic               r_valid
);
    logic [31:0] mac_cnt_q;

    always_ff @(posedge clk) begin
        if (rst || state != ST_MAC) begin
            mac_cnt_q <= '0;
        end else begin
            mac_cnt_q <= mac_cnt_q + 32'd1;
        end
    end

    AST_IDLE_TO_LOAD: assert property (@(posedge clk) disable iff (rst)
        state == ST_IDLE |=> state == ST_LOAD) else $error("idle not followed by load"); // R8
    AST_LOAD_ORDER: assert property (@(posedge clk) disable iff (rst)
        state == ST_LOAD |=> (state == ST_LOAD || state == ST_MAC)) else $error("load exit"); // R8
    AST_LOAD_LEN: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD && a_idx == cw(M)'(M-1)) |=> state == ST_MAC) else $error("load length"); // R2
    AST_MAC_STAY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MAC && mac_cnt_q < 32'(M*N-1)) |=> state == ST_MAC) else $error("accumulate short"); // R3
    AST_MAC_END: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MAC && mac_cnt_q == 32'(M*N-1)) |=> state == ST_DRAIN) else $error("accumulate long"); // R3
    AST_DRAIN_ORDER: assert property (@(posedge clk) disable iff (rst)
        state == ST_DRAIN |=> (state == ST_DRAIN || state == ST_IDLE)) else $error("drain exit"); // R8
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        state == ST_DRAIN |=> r_valid) else $error("valid missing"); // R4
    AST_VALID_LOW: assert property (@(posedge clk) disable iff (rst)
        state != ST_DRAIN |=> !r_valid) else $error("spurious valid"); // R5
    AST_CLR_WITH_WRITE: assert property (@(posedge clk) disable iff (rst)
        r_we |-> acc_clr) else $error("write without clear"); // R9
    AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (rst)
        acc_clr |=> !acc_q) else $error("accumulator not cleared"); // R9
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (state == ST_IDLE && !r_valid && !acc_q)) else $error("reset ineffective"); // R7

endmodule

bind gf2_vecmat_mul gf2mm_chk #(.M(M), .N(N)) u_chk (
    .clk     (clk_i),
    .rst     (rst_i),
    .state   (st),
    .a_idx   (a_idx),
    .r_we    (r_we),
    .acc_clr (acc_clr),
    .acc_q   (acc_q),
    .r_valid (r_valid_o)
);

// File: tb/gf2_vecmat_mul_test.sv
`timescale 1ns/1ps
module gf2_vecmat_mul_test;
    localparam int unsigned M  = 4;
    localparam int unsigned N  = 2;
    localparam logic [M*N-1:0] HB = 8'hAD;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_bit = 1'b0;
    logic r_bit, r_valid;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    gf2_vecmat_mul #(.M(M), .N(N), .H_COLMAJOR(HB)) uut (
        .clk_i     (clk),
        .rst_i     (rst),
        .a_bit_i   (a_bit),
        .r_bit_o   (r_bit),
        .r_valid_o (r_valid)
    );

    function automatic logic [N-1:0] ref_mul(input logic [M-1:0] a);
        logic [N-1:0] r = '0;
        for (int j = 0; j < N; j++)
            for (int i = 0; i < M; i++)
                r[j] = r[j] ^ (a[i] & HB[j*M+i]);
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    // one full operation, entered just after the edge that leaves idle
    task automatic run_vector(input logic [M-1:0] v);
        logic [N-1:0] exp = ref_mul(v);
        for (int i = 0; i < M; i++) begin
            a_bit = v[i];
            @(posedge clk); #1;
            check("R2 R5 valid low while loading", 32'(r_valid), 0);
        end
        for (int k = 0; k < M*N; k++) begin
            @(posedge clk); #1;
            check("R3 R5 valid low while accumulating", 32'(r_valid), 0);
        end
        for (int j = 0; j < N; j++) begin
            @(posedge clk); #1;
            check("R4 valid during drain", 32'(r_valid), 1);
            check("R1 R9 result bit", 32'(r_bit), 32'(exp[j]));
        end
        @(posedge clk); #1;
        check("R6 R8 valid low back in idle", 32'(r_valid), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R7 valid low in reset", 32'(r_valid), 0);
        rst = 1'b0;
        @(posedge clk); #1;                 // leaves idle
        // R1 known case: A=1111 gives R0=1, R1=0
        check("R1 reference model for 1111", 32'(ref_mul(4'b1111)), 32'b01);
        run_vector(4'b1111);
        // R6 R9 exhaustive back-to-back sweep
        for (int v = 0; v < (1 << M); v++) begin
            run_vector(M'(v));
        end
        // R7 abort during accumulate, then recover
        for (int i = 0; i < M; i++) begin
            a_bit = i[0];
            @(posedge clk); #1;
        end
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b1;
        @(posedge clk); #1;
        check("R7 valid low after mid-run reset", 32'(r_valid), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(posedge clk); #1;
        run_vector(4'b1111);
        run_vector(4'b1010);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule